// File: doc/BRIEF.md
# Switch Port Receive Dispatcher

This block is the receive-side decision stage of one port in a three-port packet switch. The switch has port 0 facing upstream and ports 1 and 2 facing downstream. Each packet arrives from the link as one descriptor. The descriptor gives the packet kind, the CRC verdict from an external checker, the target address and a tag that points at the packet body in the shared memory. The block decides what the packet must cause. A transaction packet receives a 12-bit sequence number, which goes back in an acknowledge record, or in a negative-acknowledge record if the CRC failed. A transaction packet with a good CRC is also routed to the send queue of its destination port. A link-control packet is handed to the local replay-buffer logic.

Each port keeps its own copy of the address-range routing table. The table is written while `init_mode` is high, before traffic starts. The block holds one packet at a time. Each of the packet's outputs is offered through its own valid/ready handshake. The next packet is accepted only when every output the current packet needs has been taken. A full queue therefore stalls the receive stream, and no packet is lost.

Top module: `rxd_port_rx`

## Requirements
- R1: After a synchronous reset, `fwd_valid`, `ack_valid` and `ctl_valid` are low, the table holds no valid range, and the first transaction packet gets sequence number 0.
- R2: While `init_mode` is high, `rx_ready` is low and a `tbl_wr` pulse stores base, limit and destination in entry `tbl_idx`. A `tbl_wr` pulse while `init_mode` is low changes nothing, which is observable through later routing.
- R3: `rx_kind` = 1 marks a transaction packet and `rx_kind` = 0 marks a link-control packet. A link-control packet with a good CRC raises `ctl_valid` with its tag and produces no forward and no ack record.
- R4: A link-control packet with a bad CRC is accepted and discarded, and no output valid rises.
- R5: A transaction packet with a good CRC produces an ack record with `ack_nak` = 0 and is forwarded, with its tag, on the `fwd_valid` lane whose index is the destination port number.
- R6: A transaction packet with a bad CRC produces an ack record with `ack_nak` = 1 and is never forwarded.
- R7: A table entry matches when base ≤ address ≤ limit, inclusive at both ends. When several entries match, the lowest entry index wins.
- R8: An address that matches no entry routes to port 0. A route that resolves to the block's own port (`PORT_ID`) is not forwarded, but the packet is still acknowledged.
- R9: Every accepted transaction packet, with a good or a bad CRC, takes the next 12-bit sequence number, wrapping from 4095 to 0. Its ack record carries that number on `ack_seq`.
- R10: An output that is valid but not ready keeps its valid signal and its data unchanged. `rx_ready` is high only outside init and when every output the held packet needs has been taken, or is being taken in the same cycle.
- R11: At most one bit of `fwd_valid` is high, and bit `PORT_ID` is never high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | Initialization phase: table writes allowed, receive blocked |
| tbl_wr | input | 1 | Table entry write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_base | input | ADDR_W | Lowest address of the range |
| tbl_limit | input | ADDR_W | Highest address of the range |
| tbl_dest | input | 2 | Destination port of the range |
| rx_valid | input | 1 | Received packet descriptor present |
| rx_ready | output | 1 | Descriptor accepted this cycle when valid |
| rx_kind | input | 1 | 1 = transaction packet, 0 = link-control packet |
| rx_crc_ok | input | 1 | CRC verdict for the packet |
| rx_addr | input | ADDR_W | Routing address of a transaction packet |
| rx_tag | input | TAG_W | Handle of the packet body in shared memory |
| fwd_valid | output | 3 | Enqueue request, one lane per destination port |
| fwd_ready | input | 3 | Destination send queue can take an entry |
| fwd_tag | output | TAG_W | Tag of the forwarded packet |
| ack_valid | output | 1 | Ack/nak record present |
| ack_ready | input | 1 | Local ack queue can take a record |
| ack_nak | output | 1 | 1 = negative acknowledge |
| ack_seq | output | 12 | Sequence number being acknowledged |
| ctl_valid | output | 1 | Link-control packet for the replay-buffer logic |
| ctl_ready | input | 1 | Replay-buffer logic can take it |
| ctl_tag | output | TAG_W | Tag of the link-control packet |

## Verification
The hardest state to reach from the ports is a held transaction packet whose ack record has already been taken while its forward request is still blocked, with a new descriptor waiting at the input. The bench reaches it by driving each ready input from its own random draw every cycle, so the outputs retire in every order. A behavioural model predicts every output and `rx_ready` on every cycle. A random run of several thousand transaction packets also carries `ack_seq` through its wrap from 4095 to 0. Directed phases stall all readies to observe overlapping-range priority, self-route drops and table writes ignored outside init.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int NPORTS        = 3;
    localparam int PORT_W        = 2;
    localparam int UPSTREAM_PORT = 0;
    localparam int SEQ_W         = 12;

    typedef enum logic {
        KIND_LINK = 1'b0,
        KIND_TXN  = 1'b1
    } pkt_kind_e;

    // What a held packet still owes to its three consumers.
    typedef struct packed {
        logic              need_fwd;
        logic              need_ack;
        logic              need_ctl;
        logic              nak;
        logic [PORT_W-1:0] dest;
    } disp_plan_t;

    function automatic logic plan_busy(disp_plan_t p);
        return p.need_fwd | p.need_ack | p.need_ctl;
    endfunction

endpackage

// File: rtl/rxd_route_table.sv
module rxd_route_table
    import rxd_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int NUM_RANGES = 4,
    localparam int IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_limit,
    input  logic [PORT_W-1:0] wr_dest,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [PORT_W-1:0] lk_dest
);

    logic [NUM_RANGES-1:0] vld_q;
    logic [ADDR_W-1:0]     base_q  [NUM_RANGES];
    logic [ADDR_W-1:0]     limit_q [NUM_RANGES];
    logic [PORT_W-1:0]     dest_q  [NUM_RANGES];
    logic [NUM_RANGES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < NUM_RANGES; i++) begin
                base_q[i]  <= '0;
                limit_q[i] <= '0;
                dest_q[i]  <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_RANGES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    vld_q[i]   <= 1'b1;
                    base_q[i]  <= wr_base;
                    limit_q[i] <= wr_limit;
                    dest_q[i]  <= wr_dest;
                end
            end
        end
    end

    for (genvar e = 0; e < NUM_RANGES; e++) begin : g_cmp
        assign match[e] = vld_q[e] && (lk_addr >= base_q[e]) && (lk_addr <= limit_q[e]);
    end

    // Lowest index wins: scan from the top so lower entries overwrite.
    always_comb begin
        lk_dest = '0;
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (match[i]) lk_dest = dest_q[i];
        end
    end

    assign lk_hit = |match;

endmodule

// File: rtl/rxd_classify.sv
module rxd_classify
    import rxd_pkg::*;
#(
    parameter int PORT_ID = 1
) (
    input  logic              kind,
    input  logic              crc_ok,
    input  logic              lk_hit,
    input  logic [PORT_W-1:0] lk_dest,
    output disp_plan_t        plan
);

    logic [PORT_W-1:0] route;

    assign route = lk_hit ? lk_dest : PORT_W'(UPSTREAM_PORT);

    always_comb begin
        plan = '0;
        if (pkt_kind_e'(kind) == KIND_TXN) begin
            plan.need_ack = 1'b1;
            plan.nak      = !crc_ok;
            plan.dest     = route;
            plan.need_fwd = crc_ok && (route != PORT_W'(PORT_ID));
        end else begin
            plan.need_ctl = crc_ok;
        end
    end

endmodule

// File: rtl/rxd_dispatch.sv
module rxd_dispatch
    import rxd_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  disp_plan_t        in_plan,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              slot_free,
    output logic [NPORTS-1:0] fwd_valid,
    input  logic [NPORTS-1:0] fwd_ready,
    output logic [TAG_W-1:0]  fwd_tag,
    output logic              ack_valid,
    input  logic              ack_ready,
    output logic              ack_nak,
    output logic [SEQ_W-1:0]  ack_seq,
    output logic              ctl_valid,
    input  logic              ctl_ready,
    output logic [TAG_W-1:0]  ctl_tag
);

    disp_plan_t       plan_q, rem_plan;
    logic [TAG_W-1:0] tag_q;
    logic [SEQ_W-1:0] hseq_q, seq_q;
    logic             fwd_fire, ack_fire, ctl_fire;

    for (genvar p = 0; p < NPORTS; p++) begin : g_lane
        assign fwd_valid[p] = plan_q.need_fwd && (plan_q.dest == PORT_W'(p));
    end

    assign fwd_tag   = tag_q;
    assign ack_valid = plan_q.need_ack;
    assign ack_nak   = plan_q.nak;
    assign ack_seq   = hseq_q;
    assign ctl_valid = plan_q.need_ctl;
    assign ctl_tag   = tag_q;

    assign fwd_fire = |(fwd_valid & fwd_ready);
    assign ack_fire = ack_valid && ack_ready;
    assign ctl_fire = ctl_valid && ctl_ready;

    always_comb begin
        rem_plan = plan_q;
        if (fwd_fire) rem_plan.need_fwd = 1'b0;
        if (ack_fire) rem_plan.need_ack = 1'b0;
        if (ctl_fire) rem_plan.need_ctl = 1'b0;
    end

    assign slot_free = !plan_busy(rem_plan);

    always_ff @(posedge clk) begin
        if (rst) begin
            plan_q <= '0;
            tag_q  <= '0;
            hseq_q <= '0;
            seq_q  <= '0;
        end else if (take) begin
            plan_q <= in_plan;
            tag_q  <= in_tag;
            if (in_plan.need_ack) begin
                hseq_q <= seq_q;
                seq_q  <= seq_q + SEQ_W'(1);
            end
        end else begin
            plan_q <= rem_plan;
        end
    end

    // Checker state: last sequence number handed to the ack queue.
    logic [SEQ_W-1:0] chk_last_q;
    logic             chk_seen_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_seen_q <= 1'b0;
            chk_last_q <= '0;
        end else if (ack_fire) begin
            chk_seen_q <= 1'b1;
            chk_last_q <= ack_seq;
        end
    end

    p_seq_step_r9: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && chk_seen_q) |-> (ack_seq == chk_last_q + SEQ_W'(1)));

    p_fwd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (|(fwd_valid & ~fwd_ready)) |=> ((fwd_valid == $past(fwd_valid)) && $stable(fwd_tag)));

    p_ack_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_nak) && $stable(ack_seq)));

    p_ctl_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_tag)));

endmodule

// File: rtl/rxd_port_rx.sv
module rxd_port_rx
    import rxd_pkg::*;
#(
    parameter  int PORT_ID    = 1,
    parameter  int ADDR_W     = 32,
    parameter  int TAG_W      = 16,
    parameter  int NUM_RANGES = 4,
    localparam int IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_mode,
    input  logic              tbl_wr,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [ADDR_W-1:0] tbl_limit,
    input  logic [1:0]        tbl_dest,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              rx_kind,
    input  logic              rx_crc_ok,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [TAG_W-1:0]  rx_tag,
    output logic [2:0]        fwd_valid,
    input  logic [2:0]        fwd_ready,
    output logic [TAG_W-1:0]  fwd_tag,
    output logic              ack_valid,
    input  logic              ack_ready,
    output logic              ack_nak,
    output logic [11:0]       ack_seq,
    output logic              ctl_valid,
    input  logic              ctl_ready,
    output logic [TAG_W-1:0]  ctl_tag
);

    logic              lk_hit;
    logic [PORT_W-1:0] lk_dest;
    disp_plan_t        plan;
    logic              slot_free;
    logic              take;

    rxd_route_table #(
        .ADDR_W     (ADDR_W),
        .NUM_RANGES (NUM_RANGES)
    ) u_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_wr && init_mode),
        .wr_idx   (tbl_idx),
        .wr_base  (tbl_base),
        .wr_limit (tbl_limit),
        .wr_dest  (tbl_dest),
        .lk_addr  (rx_addr),
        .lk_hit   (lk_hit),
        .lk_dest  (lk_dest)
    );

    rxd_classify #(
        .PORT_ID (PORT_ID)
    ) u_cls (
        .kind    (rx_kind),
        .crc_ok  (rx_crc_ok),
        .lk_hit  (lk_hit),
        .lk_dest (lk_dest),
        .plan    (plan)
    );

    assign rx_ready = !init_mode && slot_free;
    assign take     = rx_valid && rx_ready;

    rxd_dispatch #(
        .TAG_W (TAG_W)
    ) u_dsp (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .in_plan   (plan),
        .in_tag    (rx_tag),
        .slot_free (slot_free),
        .fwd_valid (fwd_valid),
        .fwd_ready (fwd_ready),
        .fwd_tag   (fwd_tag),
        .ack_valid (ack_valid),
        .ack_ready (ack_ready),
        .ack_nak   (ack_nak),
        .ack_seq   (ack_seq),
        .ctl_valid (ctl_valid),
        .ctl_ready (ctl_ready),
        .ctl_tag   (ctl_tag)
    );

    p_init_blocks_rx_r2: assert property (@(posedge clk) disable iff (rst)
        init_mode |-> !rx_ready);

    p_fwd_lane_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fwd_valid) && !fwd_valid[PORT_ID]);

    p_nak_no_fwd_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_nak) |-> (fwd_valid == 3'b000));

    p_ctl_alone_r3: assert property (@(posedge clk) disable iff (rst)
        ctl_valid |-> (!ack_valid && (fwd_valid == 3'b000)));

endmodule

// File: tb/tb_rxd_port_rx.sv
`timescale 1ns/1ps
module tb_rxd_port_rx;

    localparam int ADDR_W = 32;
    localparam int TAG_W  = 16;
    localparam int NR     = 4;
    localparam int MY     = 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              init_mode = 1'b0, tbl_wr = 1'b0;
    logic [1:0]        tbl_idx = '0, tbl_dest = '0;
    logic [ADDR_W-1:0] tbl_base = '0, tbl_limit = '0, rx_addr = '0;
    logic              rx_valid = 1'b0, rx_ready, rx_kind = 1'b0, rx_crc_ok = 1'b0;
    logic [TAG_W-1:0]  rx_tag = '0, fwd_tag, ctl_tag;
    logic [2:0]        fwd_valid, fwd_ready = '0;
    logic              ack_valid, ack_ready = 1'b0, ack_nak, ctl_valid, ctl_ready = 1'b0;
    logic [11:0]       ack_seq;

    always #2 clk = ~clk;

    rxd_port_rx #(.PORT_ID(MY), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .NUM_RANGES(NR)) dut (
        .clk(clk), .rst(rst), .init_mode(init_mode), .tbl_wr(tbl_wr), .tbl_idx(tbl_idx),
        .tbl_base(tbl_base), .tbl_limit(tbl_limit), .tbl_dest(tbl_dest),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_kind(rx_kind), .rx_crc_ok(rx_crc_ok),
        .rx_addr(rx_addr), .rx_tag(rx_tag), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
        .fwd_tag(fwd_tag), .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_nak(ack_nak),
        .ack_seq(ack_seq), .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_tag(ctl_tag)
    );

    int n_chk = 0, n_fail = 0;

    // Bench view of the routing table.
    bit          mv [NR];
    int unsigned mb [NR], ml [NR], md [NR];

    // Reference model of the held packet.
    bit          m_nf, m_na, m_nc, m_nak;
    int          m_dest;
    int unsigned m_tag, m_hseq, m_seq;

    // Stimulus state.
    bit          s_rst = 1, s_init = 0, s_valid = 0, s_kind = 0, s_crc = 0, s_wr = 0;
    int unsigned s_addr = 0, s_tag = 0, s_idx = 0, s_base = 0, s_limit = 0, s_dest = 0;
    int          rdy_mode = 0;
    bit          accepted;
    int          n_txn = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lookup(int unsigned a);
        for (int i = 0; i < NR; i++)
            if (mv[i] && a >= mb[i] && a <= ml[i]) return int'(md[i]);
        return 0;
    endfunction

    task automatic cycle();
        bit ff, fa, fc, erdy;
        logic [2:0] efv;
        @(negedge clk);
        rst = s_rst; init_mode = s_init; tbl_wr = s_wr;
        tbl_idx = s_idx[1:0]; tbl_base = s_base; tbl_limit = s_limit; tbl_dest = s_dest[1:0];
        rx_valid = s_valid; rx_kind = s_kind; rx_crc_ok = s_crc;
        rx_addr = s_addr; rx_tag = s_tag[TAG_W-1:0];
        case (rdy_mode)
            0: begin fwd_ready = 3'b111; ack_ready = 1'b1; ctl_ready = 1'b1; end
            1: begin
                fwd_ready = 3'($urandom);
                ack_ready = ($urandom % 3) != 0;
                ctl_ready = ($urandom % 3) != 0;
            end
            default: begin fwd_ready = 3'b000; ack_ready = 1'b0; ctl_ready = 1'b0; end
        endcase
        #1;
        accepted = 0;
        if (s_rst) begin
            m_nf = 0; m_na = 0; m_nc = 0; m_nak = 0; m_dest = 0; m_tag = 0; m_hseq = 0; m_seq = 0;
            for (int i = 0; i < NR; i++) mv[i] = 0;
        end else begin
            efv = m_nf ? (3'b001 << m_dest) : 3'b000;
            chk(fwd_valid == efv, "R5 R7 R8 R11 fwd_valid", fwd_valid, efv);
            if (m_nf) chk(fwd_tag == m_tag[TAG_W-1:0], "R5 fwd_tag", fwd_tag, m_tag);
            chk(ack_valid == m_na, "R5 R6 ack_valid", ack_valid, m_na);
            if (m_na) begin
                chk(ack_nak == m_nak, "R6 ack_nak", ack_nak, m_nak);
                chk(ack_seq == m_hseq[11:0], "R9 ack_seq", ack_seq, m_hseq);
            end
            chk(ctl_valid == m_nc, "R3 R4 ctl_valid", ctl_valid, m_nc);
            if (m_nc) chk(ctl_tag == m_tag[TAG_W-1:0], "R3 ctl_tag", ctl_tag, m_tag);
            ff = m_nf && !fwd_ready[m_dest];
            fa = m_na && !ack_ready;
            fc = m_nc && !ctl_ready;
            erdy = !s_init && !(ff || fa || fc);
            chk(rx_ready == erdy, "R2 R10 rx_ready", rx_ready, erdy);
            m_nf = ff; m_na = fa; m_nc = fc;
            if (s_valid && erdy) begin
                accepted = 1;
                m_tag = s_tag;
                if (s_kind) begin
                    n_txn++;
                    m_na = 1; m_nak = !s_crc; m_hseq = m_seq; m_seq = (m_seq + 1) % 4096;
                    m_dest = lookup(s_addr);
                    m_nf = s_crc && (m_dest != MY);
                    m_nc = 0;
                end else begin
                    m_na = 0; m_nf = 0; m_nc = s_crc;
                end
                s_valid = 0;
            end
            if (s_wr && s_init) begin
                mv[s_idx] = 1; mb[s_idx] = s_base; ml[s_idx] = s_limit; md[s_idx] = s_dest;
            end
        end
        s_wr = 0;
    endtask

    task automatic tbl_write(input int unsigned idx, input int unsigned b, input int unsigned l,
                             input int unsigned d);
        s_wr = 1; s_idx = idx; s_base = b; s_limit = l; s_dest = d;
        cycle();
    endtask

    task automatic send(input bit k, input bit c, input int unsigned a, input int unsigned t);
        int tries = 0;
        s_valid = 1; s_kind = k; s_crc = c; s_addr = a; s_tag = t;
        do begin cycle(); tries++; end while (!accepted && tries < 2000);
        s_valid = 0;
    endtask

    task automatic drain();
        rdy_mode = 0;
        repeat (3) cycle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    int unsigned pick [8] = '{32'h1000, 32'h1FFF, 32'h1800, 32'h2FFF, 32'h3000,
                              32'h4100, 32'h8000, 32'h5100};

    initial begin
        s_rst = 1; repeat (3) cycle();
        s_rst = 0; cycle();
        // R1: reset state
        chk(fwd_valid == 0 && !ack_valid && !ctl_valid, "R1 reset outputs",
            {fwd_valid, ack_valid, ctl_valid}, 0);

        // R2: init phase, rx blocked, table loaded
        s_init = 1;
        s_valid = 1; s_kind = 1; s_crc = 1; s_addr = 32'h1000; s_tag = 16'h0BAD;
        cycle(); chk(rx_ready == 0, "R2 rx_ready in init", rx_ready, 0);
        s_valid = 0;
        tbl_write(0, 32'h1000, 32'h1FFF, 2);
        tbl_write(1, 32'h1800, 32'h2FFF, 0);
        tbl_write(2, 32'h4000, 32'h4FFF, MY);
        s_init = 0; cycle();
        tbl_write(3, 32'h5000, 32'h5FFF, 2);   // ignored: outside init

        // R9: first sequence number is 0
        rdy_mode = 2;
        send(1, 1, 32'h1800, 16'h0011); cycle();
        chk(fwd_valid == 3'b100, "R7 overlap lowest index", fwd_valid, 3'b100);
        chk(ack_seq == 0 && !ack_nak, "R1 R9 first seq", ack_seq, 0);
        // R10: next packet waits
        s_valid = 1; s_kind = 0; s_crc = 1; s_tag = 16'h0022;
        cycle(); chk(rx_ready == 0, "R10 held packet blocks", rx_ready, 0);
        drain();

        rdy_mode = 2;
        send(1, 1, 32'h3000, 16'h0033); cycle();
        chk(fwd_valid == 3'b001, "R8 miss to upstream", fwd_valid, 3'b001);
        drain();
        rdy_mode = 2;
        send(1, 1, 32'h4100, 16'h0044); cycle();
        chk(fwd_valid == 3'b000 && ack_valid, "R8 self route dropped, acked",
            {fwd_valid, ack_valid}, 1);
        drain();
        rdy_mode = 2;
        send(1, 1, 32'h5100, 16'h0055); cycle();
        chk(fwd_valid == 3'b001, "R2 write outside init ignored", fwd_valid, 3'b001);
        drain();
        rdy_mode = 2;
        send(1, 0, 32'h1000, 16'h0066); cycle();
        chk(ack_nak && fwd_valid == 0, "R6 bad txn nak only", {ack_nak, fwd_valid}, 4'b1000);
        drain();
        rdy_mode = 2;
        send(0, 1, 32'h0, 16'h0077); cycle();
        chk(ctl_valid && !ack_valid && ctl_tag == 16'h0077, "R3 link to replay logic",
            ctl_tag, 16'h0077);
        drain();
        rdy_mode = 2;
        send(0, 0, 32'h0, 16'h0088); cycle();
        chk(!ctl_valid && !ack_valid && fwd_valid == 0 && rx_ready, "R4 bad link discarded",
            {ctl_valid, ack_valid, fwd_valid, rx_ready}, 1);
        drain();
        rdy_mode = 2;
        send(1, 1, 32'h2FFF, 16'h0099); cycle();
        chk(fwd_valid == 3'b001, "R7 inclusive limit", fwd_valid, 3'b001);
        drain();

        // Random phase: random readiness, long enough for R9 sequence wrap.
        rdy_mode = 1;
        for (int n = 0; n < 7000; n++) begin
            int unsigned a;
            a = (($urandom % 4) == 0) ? $urandom : pick[$urandom % 8];
            send(($urandom % 4) != 0, ($urandom % 8) != 0, a, $urandom);
            if ($urandom % 5 == 0) cycle();
        end
        drain();
        chk(n_txn > 4096, "R9 sequence wrapped", n_txn, 4097);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule